// File: doc/BRIEF.md
# Folded Shift-Register Flow Hash

This block reduces a 32-bit flow key to a 16-bit table hash. The hash has the same value as 32 rounds of a 16-bit shift register with feedback polynomial x^16 + x^3 + 1, started from a nonzero seed. The block does not step through the rounds one at a time. It folds them into two 16-round mixing stages, and each stage is a few shifts and XORs. Alongside the hash, the block produces an odd probe stride. An open-addressed lookup table adds this stride to the index after a collision. Because the stride is odd, the probe walk reaches every slot of a power-of-two table.

A client raises `in_valid` for one cycle with a key. One clock later, `out_valid` is high, and the hash and stride for that key are on the outputs. A new key may be accepted on every cycle. Building the key from packet headers is done elsewhere, and so is using the hash to index a table.

Top module: `nthash_unit`

## Requirements
- R1: The first mixing stage starts from 0x1fff XOR key bits [31:16]. Each mixing stage maps t to u ^ (u >> 9), where u = t ^ (t >> 3) ^ (t >> 6). All values are 16 bits wide and shifts are logical.
- R2: The second stage's input is s ^ (s << 13) ^ key bits [15:0], truncated to 16 bits, where s is the first stage's output. The second stage's output is `out_hash`.
- R3: `out_incr` equals (2 * key - 1) modulo 65536, so bit 0 of `out_incr` is always 1.
- R4: `out_valid` is high in the cycle after a cycle with `in_valid` high. The hash and stride shown then belong to that strobed key.
- R5: In a cycle after one with `in_valid` low, `out_valid` is low, and `out_hash` and `out_incr` keep their previous values whatever `in_key` does.
- R6: A synchronous active-high `rst` clears `out_valid`.
- R7: Key 0x00000000 gives hash 0x3b13 and stride 0xffff.
- R8: Keys strobed on consecutive cycles each produce their own result on consecutive cycles, with no bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Key strobe |
| in_key | input | 32 | Flow key |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_hash | output | 16 | Registered table hash |
| out_incr | output | 16 | Registered odd probe stride |

## Verification
The bench computes each expected hash from the fully expanded XOR form of a stage, t ^ t>>3 ^ t>>6 ^ t>>9 ^ t>>12 ^ t>>15. This form is written differently from the two-step mix in the design.

- Walking-one keys in the upper half isolate the seeded first stage.
- Walking-one keys in the lower half isolate the fold between the stages, including its left shift.
- The all-zero and all-ones keys test the seed and the borrow in the stride.
- A long run of pseudo-random keys, strobed back to back, shows that consecutive results do not mix.
- Gaps with a changing key show that the outputs hold their values.

// File: rtl/nthash_pkg.sv
package nthash_pkg;
  localparam int KEY_W_DEF  = 32;
  localparam int HASH_W_DEF = 16;
  localparam logic [HASH_W_DEF-1:0] SEED_DEF = 16'h1fff;
  localparam int MIX_SH_A   = 3;
  localparam int MIX_SH_B   = 6;
  localparam int MIX_SH_C   = 9;
  localparam int FOLD_SH    = 13;
endpackage

// File: rtl/nthash_mix.sv
module nthash_mix #(
  parameter int W  = 16,
  parameter int SA = 3,
  parameter int SB = 6,
  parameter int SC = 9
) (
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] first;

  always_comb begin
    first = d_in ^ (d_in >> SA) ^ (d_in >> SB);
    d_out = first ^ (first >> SC);
  end
endmodule

// File: rtl/nthash_fold.sv
module nthash_fold
  import nthash_pkg::*;
#(
  parameter int              KEY_W  = KEY_W_DEF,
  parameter int              HASH_W = HASH_W_DEF,
  parameter logic [HASH_W-1:0] SEED = SEED_DEF
) (
  input  logic [KEY_W-1:0]  key,
  output logic [HASH_W-1:0] hash
);
  localparam int STAGES = KEY_W / HASH_W;

  logic [HASH_W-1:0] st_in  [STAGES];
  logic [HASH_W-1:0] st_out [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    localparam int TOP = KEY_W - 1 - i * HASH_W;
    logic [HASH_W-1:0] chunk;
    assign chunk = key[TOP -: HASH_W];

    if (i == 0) begin : g_seed
      assign st_in[i] = SEED ^ chunk;
    end else begin : g_merge
      assign st_in[i] = st_out[i-1] ^ (st_out[i-1] << FOLD_SH) ^ chunk;
    end

    nthash_mix #(
      .W (HASH_W),
      .SA(MIX_SH_A),
      .SB(MIX_SH_B),
      .SC(MIX_SH_C)
    ) u_mix (
      .d_in (st_in[i]),
      .d_out(st_out[i])
    );
  end

  assign hash = st_out[STAGES-1];
endmodule

// File: rtl/nthash_incr.sv
module nthash_incr #(
  parameter int KEY_W  = 32,
  parameter int HASH_W = 16
) (
  input  logic [KEY_W-1:0]  key,
  output logic [HASH_W-1:0] incr
);
  logic [HASH_W-1:0] doubled;

  assign doubled = {key[HASH_W-2:0], 1'b0};
  assign incr    = doubled - HASH_W'(1);
endmodule

// File: rtl/nthash_unit.sv
module nthash_unit
  import nthash_pkg::*;
#(
  parameter int              KEY_W  = KEY_W_DEF,
  parameter int              HASH_W = HASH_W_DEF,
  parameter logic [HASH_W-1:0] SEED = SEED_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [KEY_W-1:0]  in_key,
  output logic              out_valid,
  output logic [HASH_W-1:0] out_hash,
  output logic [HASH_W-1:0] out_incr
);
  logic [HASH_W-1:0] hash_c;
  logic [HASH_W-1:0] incr_c;

  nthash_fold #(
    .KEY_W (KEY_W),
    .HASH_W(HASH_W),
    .SEED  (SEED)
  ) u_fold (
    .key (in_key),
    .hash(hash_c)
  );

  nthash_incr #(
    .KEY_W (KEY_W),
    .HASH_W(HASH_W)
  ) u_incr (
    .key (in_key),
    .incr(incr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_hash <= hash_c;
      out_incr <= incr_c;
    end
  end
endmodule

// File: rtl/nthash_chk.sv
module nthash_chk #(
  parameter int KEY_W  = 32,
  parameter int HASH_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [KEY_W-1:0]  in_key,
  input logic              out_valid,
  input logic [HASH_W-1:0] out_hash,
  input logic [HASH_W-1:0] out_incr
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R4
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_hash) && $stable(out_incr))); // R5
  AST_STRIDE_ODD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_incr[0]); // R3
  AST_STRIDE_VALUE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_incr == ({$past(in_key[HASH_W-2:0]), 1'b0} - HASH_W'(1))); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid); // R6
endmodule

bind nthash_unit nthash_chk #(
  .KEY_W (KEY_W),
  .HASH_W(HASH_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_key   (in_key),
  .out_valid(out_valid),
  .out_hash (out_hash),
  .out_incr (out_incr)
);

// File: tb/nthash_unit_bench.sv
`timescale 1ns/1ps
module nthash_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_key = '0;
  logic        out_valid;
  logic [15:0] out_hash;
  logic [15:0] out_incr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  nthash_unit u_nthash_unit (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_key   (in_key),
    .out_valid(out_valid),
    .out_hash (out_hash),
    .out_incr (out_incr)
  );

  function automatic logic [15:0] spread(input logic [15:0] t);
    return t ^ (t >> 3) ^ (t >> 6) ^ (t >> 9) ^ (t >> 12) ^ (t >> 15);
  endfunction

  function automatic logic [15:0] ref_hash(input logic [31:0] k);
    logic [15:0] a;
    logic [15:0] b;
    a = spread(16'h1fff ^ k[31:16]);
    b = a ^ {a[2:0], 13'd0} ^ k[15:0];
    return spread(b);
  endfunction

  function automatic logic [15:0] ref_incr(input logic [31:0] k);
    logic [32:0] p;
    p = {k, 1'b0} - 33'd1;
    return p[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [31:0] k, input string req);
    @(negedge clk);
    in_key   = k;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " hash"}, {16'd0, out_hash}, {16'd0, ref_hash(k)});
    check({req, " incr"}, {16'd0, out_incr}, {16'd0, ref_incr(k)});
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    logic [15:0] held_h;
    logic [15:0] held_i;
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R6 idle after reset", {31'd0, out_valid}, 32'd0);

    // R7 seed corner, known constant
    strobe(32'h0000_0000, "R7");
    check("R7 const hash", {16'd0, out_hash}, 32'h0000_3b13);
    check("R7 const incr", {16'd0, out_incr}, 32'h0000_ffff);
    strobe(32'hffff_ffff, "R3 all ones");

    // R1 walking ones in the seeded upper half
    for (int i = 16; i < 32; i++) strobe(32'd1 << i, "R1 upper walk");
    // R2 walking ones in the folded lower half
    for (int i = 0; i < 16; i++) strobe(32'd1 << i, "R2 lower walk");

    // R8 back-to-back pseudo-random keys; R4 latency
    x = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      strobe(x, "R8 R4 random");
    end

    // R5 hold with changing key and no strobe
    held_h = out_hash;
    held_i = out_incr;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_key   = 32'hdead_0000 + i;
      @(posedge clk);
      #1;
      check("R5 valid low", {31'd0, out_valid}, 32'd0);
      check("R5 hash held", {16'd0, out_hash}, {16'd0, held_h});
      check("R5 incr held", {16'd0, out_incr}, {16'd0, held_i});
    end

    // R6 reset in the middle of activity
    strobe(32'hcafe_f00d, "R4 pre-reset");
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    check("R6 mid reset", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    strobe(32'h8000_0001, "R4 post-reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule